// File: doc/BRIEF.md
# ADC Sample Sequencer FIFO Bank

This block holds the conversion results of an analog-to-digital converter for four sample sequencers, each with its own 16-entry ring buffer. A hardware trigger pulse carries a finished sample into sequencer 0's buffer, provided that sequencer has been switched on. Software reads a sequencer's data register to pop the oldest entry. A packed status word per buffer exposes the raw read and write pointers together with the full and empty flags. Overflow and underflow are never back-pressured or stalled. A push into a full buffer is dropped and a pop from an empty one is refused, and each case leaves a sticky per-sequencer flag behind.

The sample path is a plain strobe (`smp_trig` with `smp_data`) and has no ready signal, because the block never refuses a trigger at its edge. A trigger that finds the buffer full is counted as an overflow. The register port is a simple single-cycle strobe interface: a write takes effect at the clock edge where `reg_wr` is high, and read data appears on `reg_rdata` one cycle after the `reg_rd` strobe. Each sequencer also carries an input-multiplexer word and a control word that software can store and read back. The analog conversion itself happens outside this block.

Top module: `adc_seq_fifo_bank`

Register map (byte offsets): 0x00 sequencer enables (bits 3:0), 0x04 interrupt mask (bits 3:0), 0x08 raw interrupt (read), 0x0C masked interrupt on read / write-one-to-clear of raw interrupt on write, 0x10 overflow flags (write-one-to-clear), 0x14 underflow flags (write-one-to-clear). Sequencer n occupies 0x40 + n*0x20: +0x00 multiplexer word, +0x04 control word, +0x08 data (pop on read), +0x0C status.

## Requirements
- R1: After reset every buffer's status word reads 0x100 (empty, both pointers 0), the multiplexer, control, enable, mask, raw interrupt, overflow and underflow registers read 0, and `irq` is low.
- R2: The status word places the read pointer in bits 3:0, the write pointer in bits 7:4, empty in bit 8 and full in bit 12, with all other bits 0.
- R3: An accepted push stores the sample at the write pointer, advances that pointer modulo 16 and clears empty. If the new write pointer equals the read pointer, full is set.
- R4: A read of sequencer n's data register returns the entry at the read pointer, zero-extended, on `reg_rdata` one cycle later. On a non-empty buffer it advances the read pointer modulo 16 and clears full, and empty is set if the new read pointer equals the write pointer.
- R5: A push into a full buffer is dropped and sets overflow bit n. That bit stays set until a write of 1 to bit n at offset 0x10.
- R6: A pop from an empty buffer sets underflow bit n and leaves both pointers unchanged. That bit stays set until a write of 1 to bit n at offset 0x14.
- R7: `smp_trig` has no effect on any buffer or flag unless enable bit 0 is set. An accepted trigger pushes `smp_data` into sequencer 0 and sets raw interrupt bit 0, including when the push overflows.
- R8: The enable register keeps only bits 3:0, multiplexer writes are stored ANDed with 0x33333333, and the control word stores all 32 bits.
- R9: `irq` is high exactly when the raw interrupt ANDed with the mask is nonzero. Offset 0x0C reads that AND, and writing 1s there clears the matching raw bits. A set and a clear in the same cycle leave the bit set.
- R10: When a push and a pop hit a buffer in the same cycle, both take place if it is neither empty nor full, and the flags stay unchanged. On an empty buffer only the push happens and underflow is flagged. On a full buffer only the pop happens and overflow is flagged.
- R11: Writes to the data and status registers have no effect. Reads of unmapped offsets return 0, and only data-register reads change buffer state.
- R12: Sequencers 1 to 3 never receive samples: their buffers change only through pops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_trig | input | 1 | Conversion-done strobe, one sample per cycle |
| smp_data | input | SMP_W | Sample value carried by the strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| irq | output | 1 | Interrupt, raw AND mask nonzero |

## Verification
The bench builds the block with its default 12-bit sample width and 12-bit offset, so a sample that sets the top bit checks that the zero-extension into the 32-bit read word is exact. The ring depth of 16 is small enough that the bench can fill a buffer, wrap both pointers past 15 several times, and hit the full and empty edges with pushes and pops in the same cycle. A long pseudo-random mix of triggers, pops on all four sequencers and flag clears is run against a queue-based model.

// File: rtl/adc_sfb_pkg.sv
package adc_sfb_pkg;
  localparam int NSEQ     = 4;
  localparam int PTR_W    = 4;
  localparam int DEPTH    = 1 << PTR_W;
  localparam logic [31:0] MUX_KEEP = 32'h3333_3333;

  localparam int OFS_EN   = 'h00;
  localparam int OFS_MSK  = 'h04;
  localparam int OFS_RAW  = 'h08;
  localparam int OFS_MIS  = 'h0C;
  localparam int OFS_OVF  = 'h10;
  localparam int OFS_UNF  = 'h14;
  localparam int SEQ_BASE = 'h40;
  localparam int SEQ_STEP = 'h20;

  typedef enum logic [1:0] {SR_MUX, SR_CTL, SR_DATA, SR_STAT} seq_reg_e;

  typedef struct packed {
    logic     en;
    logic     msk;
    logic     raw;
    logic     mis;
    logic     ovf;
    logic     unf;
    logic     seq;
    logic [1:0] idx;
    seq_reg_e sreg;
  } dec_t;

  function automatic logic [31:0] stat_word(input logic [PTR_W-1:0] hd,
                                            input logic [PTR_W-1:0] tl,
                                            input logic full, input logic empty);
    logic [31:0] w;
    w        = '0;
    w[3:0]   = 4'(tl);
    w[7:4]   = 4'(hd);
    w[8]     = empty;
    w[12]    = full;
    return w;
  endfunction
endpackage

// File: rtl/adc_sfb_decode.sv
module adc_sfb_decode
  import adc_sfb_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  localparam int SEQ_END = SEQ_BASE + NSEQ * SEQ_STEP;

  logic [ADDR_W-1:0] rel;
  logic              in_seq;

  always_comb begin
    rel    = addr - ADDR_W'(SEQ_BASE);
    in_seq = (addr >= ADDR_W'(SEQ_BASE)) && (addr < ADDR_W'(SEQ_END));
    dec      = '0;
    dec.en   = (addr == ADDR_W'(OFS_EN));
    dec.msk  = (addr == ADDR_W'(OFS_MSK));
    dec.raw  = (addr == ADDR_W'(OFS_RAW));
    dec.mis  = (addr == ADDR_W'(OFS_MIS));
    dec.ovf  = (addr == ADDR_W'(OFS_OVF));
    dec.unf  = (addr == ADDR_W'(OFS_UNF));
    dec.seq  = in_seq && (rel[4] == 1'b0) && (rel[1:0] == 2'b00);
    dec.idx  = rel[6:5];
    dec.sreg = seq_reg_e'(rel[3:2]);
  end
endmodule

// File: rtl/adc_sfb_ring.sv
module adc_sfb_ring #(
  parameter int DW    = 12,
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [DW-1:0]    push_data,
  input  logic             pop,
  output logic [DW-1:0]    head_word,
  output logic [PTR_W-1:0] wptr,
  output logic [PTR_W-1:0] rptr,
  output logic             full,
  output logic             empty,
  output logic             ovf_evt,
  output logic             unf_evt
);
  localparam int DEPTH = 1 << PTR_W;

  logic [DW-1:0]    mem [DEPTH];
  logic             do_push, do_pop;
  logic [PTR_W-1:0] wptr_inc, rptr_inc;

  assign do_push  = push && !full;
  assign do_pop   = pop && !empty;
  assign ovf_evt  = push && full;
  assign unf_evt  = pop && empty;
  assign wptr_inc = wptr + 1'b1;
  assign rptr_inc = rptr + 1'b1;
  assign head_word = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      full  <= 1'b0;
      empty <= 1'b1;
    end else begin
      if (do_push) wptr <= wptr_inc;
      if (do_pop)  rptr <= rptr_inc;
      if (do_push && !do_pop) begin
        empty <= 1'b0;
        full  <= (wptr_inc == rptr);
      end else if (do_pop && !do_push) begin
        full  <= 1'b0;
        empty <= (rptr_inc == wptr);
      end
    end
  end
endmodule

// File: rtl/adc_seq_fifo_bank.sv
module adc_seq_fifo_bank
  import adc_sfb_pkg::*;
#(
  parameter int SMP_W  = 12,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_trig,
  input  logic [SMP_W-1:0]  smp_data,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  dec_t dec;

  logic [NSEQ-1:0]  seq_en, irq_msk, irq_raw, ovf_flg, unf_flg;
  logic [NSEQ-1:0]  ovf_evt, unf_evt, full_v, empty_v;
  logic [31:0]      mux_q [NSEQ];
  logic [31:0]      ctl_q [NSEQ];
  logic [SMP_W-1:0] hw_v  [NSEQ];
  logic [PTR_W-1:0] wp_v  [NSEQ];
  logic [PTR_W-1:0] rp_v  [NSEQ];
  logic             accept;
  logic [31:0]      rd_mux;

  adc_sfb_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(reg_addr), .dec(dec));

  assign accept = smp_trig && seq_en[0];

  for (genvar g = 0; g < NSEQ; g++) begin : g_seq
    logic push_g, pop_g;
    if (g == 0) begin : g_fed
      assign push_g = accept;
    end else begin : g_dry
      assign push_g = 1'b0;
    end
    assign pop_g = reg_rd && dec.seq && (dec.idx == 2'(g)) && (dec.sreg == SR_DATA);

    adc_sfb_ring #(.DW(SMP_W), .PTR_W(PTR_W)) u_ring (
      .clk      (clk),
      .rst      (rst),
      .push     (push_g),
      .push_data(smp_data),
      .pop      (pop_g),
      .head_word(hw_v[g]),
      .wptr     (wp_v[g]),
      .rptr     (rp_v[g]),
      .full     (full_v[g]),
      .empty    (empty_v[g]),
      .ovf_evt  (ovf_evt[g]),
      .unf_evt  (unf_evt[g])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        mux_q[g] <= '0;
        ctl_q[g] <= '0;
      end else if (reg_wr && dec.seq && (dec.idx == 2'(g))) begin
        if (dec.sreg == SR_MUX) mux_q[g] <= reg_wdata & MUX_KEEP;
        if (dec.sreg == SR_CTL) ctl_q[g] <= reg_wdata;
      end
    end
  end

  // Global registers; a new event wins over a same-cycle clear.
  always_ff @(posedge clk) begin
    if (rst) begin
      seq_en  <= '0;
      irq_msk <= '0;
      irq_raw <= '0;
      ovf_flg <= '0;
      unf_flg <= '0;
    end else begin
      if (reg_wr && dec.en)  seq_en  <= reg_wdata[NSEQ-1:0];
      if (reg_wr && dec.msk) irq_msk <= reg_wdata[NSEQ-1:0];
      irq_raw <= (irq_raw & ~((reg_wr && dec.mis) ? reg_wdata[NSEQ-1:0] : '0))
                 | {{(NSEQ-1){1'b0}}, accept};
      ovf_flg <= (ovf_flg & ~((reg_wr && dec.ovf) ? reg_wdata[NSEQ-1:0] : '0)) | ovf_evt;
      unf_flg <= (unf_flg & ~((reg_wr && dec.unf) ? reg_wdata[NSEQ-1:0] : '0)) | unf_evt;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (dec.en)  rd_mux[NSEQ-1:0] = seq_en;
    if (dec.msk) rd_mux[NSEQ-1:0] = irq_msk;
    if (dec.raw) rd_mux[NSEQ-1:0] = irq_raw;
    if (dec.mis) rd_mux[NSEQ-1:0] = irq_raw & irq_msk;
    if (dec.ovf) rd_mux[NSEQ-1:0] = ovf_flg;
    if (dec.unf) rd_mux[NSEQ-1:0] = unf_flg;
    if (dec.seq) begin
      unique case (dec.sreg)
        SR_MUX:  rd_mux = mux_q[dec.idx];
        SR_CTL:  rd_mux = ctl_q[dec.idx];
        SR_DATA: rd_mux = 32'(hw_v[dec.idx]);
        SR_STAT: rd_mux = stat_word(wp_v[dec.idx], rp_v[dec.idx],
                                    full_v[dec.idx], empty_v[dec.idx]);
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  assign irq = |(irq_raw & irq_msk);
endmodule

// File: rtl/adc_seq_fifo_bank_chk.sv
module adc_seq_fifo_bank_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              smp_trig,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [3:0]        seq_en,
  input logic [3:0]        irq_raw,
  input logic [3:0]        ovf_flg,
  input logic [3:0]        unf_flg,
  input logic [3:0]        full_v,
  input logic [3:0]        empty_v,
  input logic [3:0]        wp0,
  input logic [3:0]        rp0
);
  logic pop0, clr_ovf0;
  assign pop0     = reg_rd && (reg_addr == ADDR_W'('h48));
  assign clr_ovf0 = reg_wr && (reg_addr == ADDR_W'('h10)) && reg_wdata[0];

  // R2
  ring_flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(full_v[0] && empty_v[0]));

  // R7
  trig_gated_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_trig && !seq_en[0] && !reg_wr && !reg_rd) |=> ($stable(irq_raw) && $stable(wp0) && $stable(ovf_flg)));

  // R5
  push_full_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_trig && seq_en[0] && full_v[0]) |=> ovf_flg[0]);

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_flg[0] && !clr_ovf0) |=> ovf_flg[0]);

  // R6
  pop_empty_unf_chk: assert property (@(posedge clk) disable iff (rst)
    (pop0 && empty_v[0] && !smp_trig) |=> (unf_flg[0] && $stable(rp0) && $stable(wp0)));
endmodule

bind adc_seq_fifo_bank adc_seq_fifo_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .smp_trig (smp_trig),
  .reg_wr   (reg_wr),
  .reg_rd   (reg_rd),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .seq_en   (seq_en),
  .irq_raw  (irq_raw),
  .ovf_flg  (ovf_flg),
  .unf_flg  (unf_flg),
  .full_v   (full_v),
  .empty_v  (empty_v),
  .wp0      (wp_v[0]),
  .rp0      (rp_v[0])
);

// File: tb/adc_seq_fifo_bank_tb.sv
module adc_seq_fifo_bank_tb;
  localparam int SW = 12;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          smp_trig = 1'b0;
  logic [SW-1:0] smp_data = '0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          irq;

  int total = 0, bad = 0;
  bit done = 0;

  // Behavioural model.
  logic [SW-1:0] q [4][$];
  int            hd [4], tl [4];
  logic [3:0]    m_en, m_msk, m_raw, m_ovf, m_unf;
  logic [31:0]   m_mux [4], m_ctl [4];

  always #5 clk = ~clk;

  adc_seq_fifo_bank #(.SMP_W(SW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .smp_trig(smp_trig), .smp_data(smp_data),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  task automatic chk(input bit ok, input string req, input logic [31:0] a, input logic [31:0] e);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, a, e);
    end
  endtask

  function automatic logic [31:0] m_stat(int n);
    logic [31:0] w = '0;
    w[3:0] = 4'(tl[n]);
    w[7:4] = 4'(hd[n]);
    w[8]   = (q[n].size() == 0);
    w[12]  = (q[n].size() == 16);
    return w;
  endfunction

  task automatic model_reset();
    for (int n = 0; n < 4; n++) begin
      q[n].delete(); hd[n] = 0; tl[n] = 0; m_mux[n] = 0; m_ctl[n] = 0;
    end
    m_en = 0; m_msk = 0; m_raw = 0; m_ovf = 0; m_unf = 0;
  endtask

  // One bus cycle; model advanced and outputs compared after the edge.
  task automatic cyc(input bit wr, input bit rd, input int addr, input logic [31:0] wd,
                     input bit tg, input logic [SW-1:0] sd, input string req);
    logic [31:0] erd;
    bit          chk_rd;
    int          sq, rg;
    bit          is_seq, push, popn [4];
    logic [3:0]  n_ovf, n_unf, n_raw;
    @(negedge clk);
    smp_trig = tg; smp_data = sd; reg_wr = wr; reg_rd = rd;
    reg_addr = AW'(addr); reg_wdata = wd;
    is_seq = (addr >= 'h40) && (addr < 'hC0) && ((addr & 'h13) == 0);
    sq = (addr - 'h40) >> 5; rg = (addr >> 2) & 3;
    erd = 0; chk_rd = rd;
    if (rd) begin
      if (is_seq) begin
        case (rg)
          0: erd = m_mux[sq];
          1: erd = m_ctl[sq];
          2: if (q[sq].size() > 0) erd = 32'(q[sq][0]); else chk_rd = 0;
          default: erd = m_stat(sq);
        endcase
      end else case (addr)
        'h00: erd = 32'(m_en);
        'h04: erd = 32'(m_msk);
        'h08: erd = 32'(m_raw);
        'h0C: erd = 32'(m_raw & m_msk);
        'h10: erd = 32'(m_ovf);
        'h14: erd = 32'(m_unf);
        default: erd = 0;
      endcase
    end
    // next state, decided on the state before the edge
    push = tg && m_en[0];
    n_ovf = m_ovf; n_unf = m_unf; n_raw = m_raw;
    for (int n = 0; n < 4; n++) popn[n] = rd && is_seq && (sq == n) && (rg == 2);
    if (wr && addr == 'h0C) n_raw &= ~wd[3:0];
    if (wr && addr == 'h10) n_ovf &= ~wd[3:0];
    if (wr && addr == 'h14) n_unf &= ~wd[3:0];
    if (push) n_raw[0] = 1'b1;
    for (int n = 0; n < 4; n++) begin
      int sz = q[n].size();
      bit pu = push && (n == 0);
      if (pu && sz == 16) n_ovf[n] = 1'b1;
      if (popn[n] && sz == 0) n_unf[n] = 1'b1;
      if (popn[n] && sz > 0) begin void'(q[n].pop_front()); tl[n] = (tl[n] + 1) % 16; end
      if (pu && sz < 16) begin q[n].push_back(sd); hd[n] = (hd[n] + 1) % 16; end
    end
    if (wr && addr == 'h00) m_en = wd[3:0];
    if (wr && addr == 'h04) m_msk = wd[3:0];
    if (wr && is_seq && rg == 0) m_mux[sq] = wd & 32'h3333_3333;
    if (wr && is_seq && rg == 1) m_ctl[sq] = wd;
    m_raw = n_raw; m_ovf = n_ovf; m_unf = n_unf;
    @(posedge clk); #1;
    if (chk_rd) chk(reg_rdata === erd, req, reg_rdata, erd);
    chk(irq === |(m_raw & m_msk), {req, " R9 irq"}, 32'(irq), 32'(|(m_raw & m_msk)));
    smp_trig = 0; reg_wr = 0; reg_rd = 0;
  endtask

  task automatic rd_reg(input int a, input string req);
    cyc(0, 1, a, 0, 0, 0, req);
  endtask
  task automatic wr_reg(input int a, input logic [31:0] d, input string req);
    cyc(1, 0, a, d, 0, 0, req);
  endtask
  task automatic trig(input logic [SW-1:0] d, input string req);
    cyc(0, 0, 0, 0, 1, d, req);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 / R2 reset state
    for (int n = 0; n < 4; n++) begin
      rd_reg('h4C + n * 'h20, "R1 R2 status");
      rd_reg('h40 + n * 'h20, "R1 mux");
      rd_reg('h44 + n * 'h20, "R1 ctl");
    end
    rd_reg('h00, "R1 en"); rd_reg('h08, "R1 raw"); rd_reg('h10, "R1 ovf"); rd_reg('h14, "R1 unf");
    // R7 gated trigger
    trig(12'h111, "R7");
    rd_reg('h4C, "R7 status"); rd_reg('h08, "R7 raw");
    // R8 masking
    wr_reg('h00, 32'hFFFF_FFF1, "R8"); rd_reg('h00, "R8 en");
    wr_reg('h60, 32'hFFFF_FFFF, "R8"); rd_reg('h60, "R8 mux");
    wr_reg('hA4, 32'hDEAD_BEEF, "R8"); rd_reg('hA4, "R8 ctl");
    // R3 push, R9 irq
    wr_reg('h04, 32'h1, "R9");
    trig(12'hA01, "R3"); trig(12'hFFF, "R3"); trig(12'h5A5, "R3");
    rd_reg('h4C, "R3 status"); rd_reg('h0C, "R9 mis");
    // R11 ignored writes and unmapped reads
    wr_reg('h48, 32'h0, "R11"); wr_reg('h4C, 32'hFFFF, "R11");
    rd_reg('h4C, "R11 status"); rd_reg('h1C, "R11 unmapped"); rd_reg('h50, "R11 hole");
    // R4 pops
    rd_reg('h48, "R4 data"); rd_reg('h48, "R4 data"); rd_reg('h4C, "R4 status");
    // R9 raw clear with simultaneous set
    cyc(1, 0, 'h0C, 32'h1, 1, 12'h0C3, "R9 set wins");
    rd_reg('h08, "R9 raw");
    wr_reg('h0C, 32'hF, "R9 clear"); rd_reg('h08, "R9 raw clr");
    // R5 fill to full and overflow
    for (int i = 0; i < 14; i++) trig(SW'(i * 37 + 3), "R3 fill");
    rd_reg('h4C, "R3 full");
    trig(12'h777, "R5 drop"); rd_reg('h10, "R5 ovf"); rd_reg('h4C, "R5 status");
    // R10 push+pop on full: pop only, ovf
    wr_reg('h10, 32'h1, "R5 clr"); rd_reg('h10, "R5 ovf clr");
    cyc(0, 1, 'h48, 0, 1, 12'h888, "R10 full");
    rd_reg('h10, "R10 ovf"); rd_reg('h4C, "R10 status");
    // R10 mid-level both
    cyc(0, 1, 'h48, 0, 1, 12'h999, "R10 mid"); rd_reg('h4C, "R10 status");
    // R6 drain and underflow
    for (int i = 0; i < 16; i++) rd_reg('h48, "R4 drain");
    rd_reg('h4C, "R6 status"); rd_reg('h14, "R6 unf");
    // R10 push+pop on empty
    wr_reg('h14, 32'hF, "R6 clr");
    cyc(0, 1, 'h48, 0, 1, 12'h321, "R10 empty"); rd_reg('h14, "R10 unf"); rd_reg('h4C, "R10 status");
    // R12 other sequencers
    rd_reg('h88, "R12 pop"); rd_reg('h14, "R12 unf"); rd_reg('h8C, "R12 status");
    // mixed traffic with wraparound
    lf = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      int a;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      case (lf[2:0])
        0, 1:    a = 'h48;
        2:       a = 'h4C;
        3:       a = 'h48 + 'h20 * int'(lf[4:3]);
        4:       a = 'h10;
        5:       a = 'h14;
        6:       a = 'h0C;
        default: a = 'h08;
      endcase
      cyc(lf[2:0] >= 4 && lf[5], lf[6] | ~lf[5], a, 32'(lf[11:8]), lf[7] | lf[9], SW'(lf), "R3 R4 mix");
    end
    // R1 reset again
    @(negedge clk); rst = 1; @(negedge clk); rst = 0; model_reset();
    rd_reg('h4C, "R1 re-reset"); rd_reg('h00, "R1 en");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule